// File: doc/BRIEF.md
# Vector Integer Multiply-Accumulate Lane

This block is one element lane of a vector execution unit. Each cycle it may accept one element operation. The lane can return the low half of a product, or the high half under one of three signedness pairings. It also performs four fused multiply-add forms. In two of these forms the old destination element is the addend. In the other two the old destination is the multiplicand. The element width is chosen per operation from 8, 16, 32 or 64 bits.

The lane is fully pipelined. With the default parameters a result appears two clock cycles after its element is issued, and a new element can be issued in every cycle. When the scalar form is selected, a general-purpose register value takes the place of the vs1 operand. A cleared mask bit makes the lane return the old destination element unchanged, and the valid output still fires.

Top module: `vmac_lane`

## Requirements
- R1: While rst_n is low, and after reset until the first element is issued, out_valid is 0. An element still in flight when reset is asserted produces no output.
- R2: With MUL_REG=1, out_valid is 1 exactly two cycles after each cycle in which in_valid is 1. Elements issued in consecutive cycles come out in consecutive cycles and in issue order.
- R3: op code 0 returns the low SEW bits of vs2 times vs1.
- R4: op code 1 returns the high SEW bits of the product with both operands signed. Op code 2 returns them with both operands unsigned. Op code 3 returns them with vs2 signed and vs1 unsigned.
- R5: op code 4 returns vd + vs1*vs2. Op code 5 returns vd - vs1*vs2.
- R6: op code 6 returns vs1*vd + vs2. Op code 7 returns vs2 - vs1*vd.
- R7: in_sew codes 0, 1, 2 and 3 select element widths of 8, 16, 32 and 64 bits. Only the low SEW bits of every operand are used. Results wrap modulo 2^SEW, and for an active element the bits of out_result above SEW are 0.
- R8: when in_scalar_en is 1, the low SEW bits of in_scalar replace vs1 and in_vs1 has no effect on the result.
- R9: when in_mask is 0, out_result equals the full in_vd of that element, whatever the op code and width, and out_valid still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Element issued this cycle |
| in_op | input | 3 | Operation code (0..7, see R3 to R6) |
| in_sew | input | 2 | Element width code (see R7) |
| in_mask | input | 1 | 1 = active element, 0 = keep old destination |
| in_scalar_en | input | 1 | 1 = use in_scalar in place of vs1 |
| in_vs2 | input | 64 | Source element vs2 |
| in_vs1 | input | 64 | Source element vs1 |
| in_scalar | input | 64 | Scalar register operand |
| in_vd | input | 64 | Old destination element |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Result element |

## Verification
While the product register is finishing one element, the next element is already passing through operand extension. So an active element and a masked element can share the pipeline in the same cycle, as can two different widths or signedness choices. The bench provokes this with a stream issued in consecutive cycles. The stream mixes a masked pass-through, a high-half product, a destination-as-multiplicand form and a scalar form. At each cycle of the drain, out_result is compared with a behavioural reference for the element issued two cycles earlier, which catches any stage that picks up the width, mask or addend of its neighbour.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

   localparam int unsigned MAX_ELEN = 64;

   typedef enum logic [2:0] {
      OP_MUL_LO  = 3'd0,
      OP_HI_SS   = 3'd1,
      OP_HI_UU   = 3'd2,
      OP_HI_SU   = 3'd3,
      OP_ACC_ADD = 3'd4,
      OP_ACC_SUB = 3'd5,
      OP_FMA_ADD = 3'd6,
      OP_FMA_SUB = 3'd7
   } op_e;

   // element width in bits for a width code, clamped to the lane width
   function automatic int unsigned elem_bits(input logic [1:0] sew, input int unsigned elen);
      int unsigned w;
      w = 32'd8 << sew;
      return (w > elen) ? elen : w;
   endfunction

   // ones in the low w bit positions
   function automatic logic [MAX_ELEN-1:0] ones_below(input int unsigned w);
      logic [MAX_ELEN-1:0] one_v;
      one_v = {{(MAX_ELEN-1){1'b0}}, 1'b1};
      if (w >= MAX_ELEN) return '1;
      return (one_v << w) - one_v;
   endfunction

endpackage

// File: rtl/vmac_operand_ext.sv
module vmac_operand_ext
   import vmac_pkg::*;
#(
   parameter int unsigned ELEN = 64
) (
   input  logic [ELEN-1:0] val,
   input  logic [1:0]      sew,
   input  logic            sgn,
   output logic [ELEN:0]   ext
);

   logic [MAX_ELEN-1:0] full_m;
   logic [ELEN-1:0]     lowm;
   logic                top_bit;
   logic                fill;

   always_comb begin
      full_m  = ones_below(elem_bits(sew, ELEN));
      lowm    = full_m[ELEN-1:0];
      top_bit = |(val & lowm & ~(lowm >> 1));
      fill    = sgn & top_bit;
      ext     = {fill, (val & lowm) | ({ELEN{fill}} & ~lowm)};
   end

endmodule

// File: rtl/vmac_mul_stage.sv
module vmac_mul_stage #(
   parameter int unsigned ELEN    = 64,
   parameter bit          MUL_REG = 1'b1,
   localparam int unsigned PW     = 2*ELEN+2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            i_valid,
   input  logic [2:0]      i_op,
   input  logic [1:0]      i_sew,
   input  logic            i_mask,
   input  logic [ELEN-1:0] i_vd,
   input  logic [ELEN-1:0] i_addend,
   input  logic [ELEN:0]   i_a,
   input  logic [ELEN:0]   i_b,
   output logic            o_valid,
   output logic [2:0]      o_op,
   output logic [1:0]      o_sew,
   output logic            o_mask,
   output logic [ELEN-1:0] o_vd,
   output logic [ELEN-1:0] o_addend,
   output logic [PW-1:0]   o_prod
);

   logic signed [PW-1:0] prod;
   assign prod = $signed(i_a) * $signed(i_b);

   generate
      if (MUL_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_valid  <= 1'b0;
               o_op     <= '0;
               o_sew    <= '0;
               o_mask   <= 1'b0;
               o_vd     <= '0;
               o_addend <= '0;
               o_prod   <= '0;
            end else begin
               o_valid  <= i_valid;
               o_op     <= i_op;
               o_sew    <= i_sew;
               o_mask   <= i_mask;
               o_vd     <= i_vd;
               o_addend <= i_addend;
               o_prod   <= prod;
            end
         end
      end else begin : g_comb
         assign o_valid  = i_valid;
         assign o_op     = i_op;
         assign o_sew    = i_sew;
         assign o_mask   = i_mask;
         assign o_vd     = i_vd;
         assign o_addend = i_addend;
         assign o_prod   = prod;
      end
   endgenerate

endmodule

// File: rtl/vmac_combine.sv
module vmac_combine
   import vmac_pkg::*;
#(
   parameter int unsigned ELEN = 64,
   localparam int unsigned PW  = 2*ELEN+2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            s_valid,
   input  logic [2:0]      s_op,
   input  logic [1:0]      s_sew,
   input  logic            s_mask,
   input  logic [ELEN-1:0] s_vd,
   input  logic [ELEN-1:0] s_addend,
   input  logic [PW-1:0]   s_prod,
   output logic            out_valid,
   output logic [ELEN-1:0] out_result
);

   int unsigned         w;
   logic [MAX_ELEN-1:0] full_m;
   logic [ELEN-1:0]     lowm;
   logic [PW-1:0]       hi_all;
   logic [ELEN-1:0]     lo;
   logic [ELEN-1:0]     raw;
   logic [ELEN-1:0]     nxt;

   always_comb begin
      w      = elem_bits(s_sew, ELEN);
      full_m = ones_below(w);
      lowm   = full_m[ELEN-1:0];
      hi_all = s_prod >> w;
      lo     = s_prod[ELEN-1:0];
      unique case (op_e'(s_op))
         OP_MUL_LO:             raw = lo;
         OP_HI_SS, OP_HI_UU,
         OP_HI_SU:              raw = hi_all[ELEN-1:0];
         OP_ACC_ADD, OP_FMA_ADD: raw = s_addend + lo;
         default:               raw = s_addend - lo;
      endcase
      nxt = s_mask ? (raw & lowm) : s_vd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid  <= s_valid;
         out_result <= nxt;
      end
   end

endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
   import vmac_pkg::*;
#(
   parameter int unsigned ELEN    = 64,
   parameter bit          MUL_REG = 1'b1,
   localparam int unsigned PW     = 2*ELEN+2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [2:0]      in_op,
   input  logic [1:0]      in_sew,
   input  logic            in_mask,
   input  logic            in_scalar_en,
   input  logic [ELEN-1:0] in_vs2,
   input  logic [ELEN-1:0] in_vs1,
   input  logic [ELEN-1:0] in_scalar,
   input  logic [ELEN-1:0] in_vd,
   output logic            out_valid,
   output logic [ELEN-1:0] out_result
);

   generate
      if (!(ELEN == 8 || ELEN == 16 || ELEN == 32 || ELEN == 64)) begin : g_bad_elen
         $error("vmac_lane: ELEN must be 8, 16, 32 or 64");
      end
   endgenerate

   logic            dest_is_mult;
   logic            a_sgn;
   logic            b_sgn;
   logic [ELEN-1:0] a_raw;
   logic [ELEN-1:0] b_raw;
   logic [ELEN-1:0] addend;
   logic [ELEN:0]   a_ext;
   logic [ELEN:0]   b_ext;

   always_comb begin
      dest_is_mult = (in_op == OP_FMA_ADD) || (in_op == OP_FMA_SUB);
      a_sgn        = (in_op == OP_HI_SS) || (in_op == OP_HI_SU);
      b_sgn        = (in_op == OP_HI_SS);
      a_raw        = dest_is_mult ? in_vd  : in_vs2;
      addend       = dest_is_mult ? in_vs2 : in_vd;
      b_raw        = in_scalar_en ? in_scalar : in_vs1;
   end

   vmac_operand_ext #(.ELEN(ELEN)) u_ext_a (
      .val (a_raw),
      .sew (in_sew),
      .sgn (a_sgn),
      .ext (a_ext)
   );

   vmac_operand_ext #(.ELEN(ELEN)) u_ext_b (
      .val (b_raw),
      .sew (in_sew),
      .sgn (b_sgn),
      .ext (b_ext)
   );

   logic            m_valid;
   logic [2:0]      m_op;
   logic [1:0]      m_sew;
   logic            m_mask;
   logic [ELEN-1:0] m_vd;
   logic [ELEN-1:0] m_addend;
   logic [PW-1:0]   m_prod;

   vmac_mul_stage #(.ELEN(ELEN), .MUL_REG(MUL_REG)) u_mul (
      .clk      (clk),
      .rst_n    (rst_n),
      .i_valid  (in_valid),
      .i_op     (in_op),
      .i_sew    (in_sew),
      .i_mask   (in_mask),
      .i_vd     (in_vd),
      .i_addend (addend),
      .i_a      (a_ext),
      .i_b      (b_ext),
      .o_valid  (m_valid),
      .o_op     (m_op),
      .o_sew    (m_sew),
      .o_mask   (m_mask),
      .o_vd     (m_vd),
      .o_addend (m_addend),
      .o_prod   (m_prod)
   );

   vmac_combine #(.ELEN(ELEN)) u_comb (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_valid    (m_valid),
      .s_op       (m_op),
      .s_sew      (m_sew),
      .s_mask     (m_mask),
      .s_vd       (m_vd),
      .s_addend   (m_addend),
      .s_prod     (m_prod),
      .out_valid  (out_valid),
      .out_result (out_result)
   );

endmodule

// File: rtl/vmac_lane_chk.sv
module vmac_lane_chk
   import vmac_pkg::*;
#(
   parameter int unsigned ELEN    = 64,
   parameter bit          MUL_REG = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [2:0]      in_op,
   input logic [1:0]      in_sew,
   input logic            in_mask,
   input logic            in_scalar_en,
   input logic [ELEN-1:0] in_vs2,
   input logic [ELEN-1:0] in_vs1,
   input logic [ELEN-1:0] in_scalar,
   input logic [ELEN-1:0] in_vd,
   input logic            out_valid,
   input logic [ELEN-1:0] out_result
);

   localparam int unsigned L = MUL_REG ? 2 : 1;

   logic            d_valid [L];
   logic [2:0]      d_op    [L];
   logic [1:0]      d_sew   [L];
   logic            d_mask  [L];
   logic            d_sc    [L];
   logic [ELEN-1:0] d_vs2   [L];
   logic [ELEN-1:0] d_vs1   [L];
   logic [ELEN-1:0] d_scal  [L];
   logic [ELEN-1:0] d_vd    [L];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < L; k++) begin
            d_valid[k] <= 1'b0; d_op[k] <= '0; d_sew[k] <= '0; d_mask[k] <= 1'b0;
            d_sc[k] <= 1'b0; d_vs2[k] <= '0; d_vs1[k] <= '0; d_scal[k] <= '0; d_vd[k] <= '0;
         end
      end else begin
         d_valid[0] <= in_valid; d_op[0] <= in_op; d_sew[0] <= in_sew; d_mask[0] <= in_mask;
         d_sc[0] <= in_scalar_en; d_vs2[0] <= in_vs2; d_vs1[0] <= in_vs1;
         d_scal[0] <= in_scalar; d_vd[0] <= in_vd;
         for (int k = 1; k < L; k++) begin
            d_valid[k] <= d_valid[k-1]; d_op[k] <= d_op[k-1]; d_sew[k] <= d_sew[k-1];
            d_mask[k] <= d_mask[k-1]; d_sc[k] <= d_sc[k-1]; d_vs2[k] <= d_vs2[k-1];
            d_vs1[k] <= d_vs1[k-1]; d_scal[k] <= d_scal[k-1]; d_vd[k] <= d_vd[k-1];
         end
      end
   end

   logic [MAX_ELEN-1:0] full_m;
   logic [ELEN-1:0]     tail_m;
   always_comb begin
      full_m = ones_below(elem_bits(d_sew[L-1], ELEN));
      tail_m = full_m[ELEN-1:0];
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == d_valid[L-1]);

   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid[L-1] && !d_mask[L-1]) |-> (out_result == d_vd[L-1]));

   // R7
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid[L-1] && d_mask[L-1]) |-> ((out_result & ~tail_m) == '0));

   // R3
   unit_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid[L-1] && d_mask[L-1] && d_op[L-1] == 3'd0 && !d_sc[L-1] &&
       (d_vs1[L-1] & tail_m) == ELEN'(1)) |-> (out_result == (d_vs2[L-1] & tail_m)));

   // R8
   scalar_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid[L-1] && d_mask[L-1] && d_op[L-1] == 3'd0 && d_sc[L-1] &&
       (d_scal[L-1] & tail_m) == ELEN'(1)) |-> (out_result == (d_vs2[L-1] & tail_m)));

endmodule

bind vmac_lane vmac_lane_chk #(.ELEN(ELEN), .MUL_REG(MUL_REG)) u_chk (.*);

// File: tb/tb_vmac_lane.sv
`timescale 1ns/1ps
module tb_vmac_lane;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = '0;
   logic [1:0]  in_sew = '0;
   logic        in_mask = 1'b0;
   logic        in_scalar_en = 1'b0;
   logic [63:0] in_vs2 = '0, in_vs1 = '0, in_scalar = '0, in_vd = '0;
   logic        out_valid;
   logic [63:0] out_result;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   vmac_lane dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_sew(in_sew),
      .in_mask(in_mask), .in_scalar_en(in_scalar_en), .in_vs2(in_vs2), .in_vs1(in_vs1),
      .in_scalar(in_scalar), .in_vd(in_vd), .out_valid(out_valid), .out_result(out_result)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  sew;
      logic [63:0] vs2;
      logic [63:0] vs1;
      logic [63:0] vd;
      logic [63:0] exp;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VT [NV] = '{
      '{3'd0, 2'd0, 64'h0F, 64'h11, 64'h0, 64'hFF},
      '{3'd0, 2'd0, 64'h80, 64'h02, 64'h0, 64'h00},
      '{3'd1, 2'd0, 64'h80, 64'h80, 64'h0, 64'h40},
      '{3'd2, 2'd0, 64'hFF, 64'hFF, 64'h0, 64'hFE},
      '{3'd1, 2'd0, 64'hFF, 64'hFF, 64'h0, 64'h00},
      '{3'd3, 2'd0, 64'hFF, 64'hFF, 64'h0, 64'hFF},
      '{3'd3, 2'd1, 64'h8000, 64'h0002, 64'h0, 64'hFFFF},
      '{3'd4, 2'd1, 64'h4, 64'h3, 64'h10, 64'h1C},
      '{3'd5, 2'd1, 64'h1, 64'h1, 64'h0, 64'hFFFF},
      '{3'd6, 2'd2, 64'h7, 64'h6, 64'h5, 64'h25},
      '{3'd7, 2'd2, 64'h1, 64'h3, 64'h2, 64'hFFFF_FFFB},
      '{3'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE},
      '{3'd1, 2'd3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 64'h4000_0000_0000_0000},
      '{3'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
      '{3'd0, 2'd2, 64'hDEAD_0000_0000_0003, 64'hBEEF_0000_0000_0005, 64'h0, 64'hF},
      '{3'd4, 2'd3, 64'h1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}
   };

   function automatic string op_tag(input logic [2:0] op);
      if (op == 3'd0) return "R3";
      if (op <= 3'd3) return "R4";
      if (op <= 3'd5) return "R5";
      return "R6";
   endfunction

   function automatic logic [63:0] wmask(input logic [1:0] sew);
      int w = 8 << sew;
      return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
   endfunction

   function automatic logic signed [129:0] as_num(input logic [63:0] x, input int w, input bit sgn);
      logic signed [129:0] r;
      logic signed [129:0] one;
      one = 130'sd1;
      r = $signed({66'd0, x});
      if (sgn && x[w-1]) r = r - (one <<< w);
      return r;
   endfunction

   function automatic logic [63:0] ref_res(input logic [2:0] op, input logic [1:0] sew,
                                           input logic [63:0] vs2, input logic [63:0] b,
                                           input logic [63:0] vd);
      int w = 8 << sew;
      logic [63:0] m = wmask(sew);
      logic [63:0] x2 = vs2 & m;
      logic [63:0] x1 = b & m;
      logic signed [129:0] p;
      logic [63:0] r;
      case (op)
         3'd0: r = x2 * x1;
         3'd1, 3'd2, 3'd3: begin
            p = as_num(x2, w, op != 3'd2) * as_num(x1, w, op == 3'd1);
            r = p[w +: 64];
         end
         3'd4: r = vd + x1 * x2;
         3'd5: r = vd - x1 * x2;
         3'd6: r = x1 * vd + vs2;
         default: r = vs2 - x1 * vd;
      endcase
      return r & m;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [1:0] sew, input bit mk, input bit sc,
                        input logic [63:0] vs2, input logic [63:0] vs1,
                        input logic [63:0] scal, input logic [63:0] vd);
      in_valid = 1'b1; in_op = op; in_sew = sew; in_mask = mk; in_scalar_en = sc;
      in_vs2 = vs2; in_vs1 = vs1; in_scalar = scal; in_vd = vd;
   endtask

   // issue at a falling edge, result visible at the second falling edge after it
   task automatic apply(input string tag, input logic [2:0] op, input logic [1:0] sew,
                        input bit mk, input bit sc, input logic [63:0] vs2,
                        input logic [63:0] vs1, input logic [63:0] scal,
                        input logic [63:0] vd, input logic [63:0] exp);
      @(negedge clk);
      drive(op, sew, mk, sc, vs2, vs1, scal, vd);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
      check(tag, out_result, exp);
   endtask

   function automatic logic [63:0] pick(input logic [1:0] sew);
      int w = 8 << sew;
      logic [63:0] v = {$urandom, $urandom};
      case ($urandom_range(0, 5))
         0: v = 64'd1 << (w - 1);
         1: v = (64'd1 << (w - 1)) - 64'd1;
         2: v = 64'hFFFF_FFFF_FFFF_FFFF;
         3: v = 64'd0;
         default: ;
      endcase
      return v;
   endfunction

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: quiet during and after reset
      repeat (4) @(negedge clk);
      check("R1 in reset", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 after reset", {63'd0, out_valid}, 64'd0);

      // table of directed vectors
      for (int i = 0; i < NV; i++)
         apply(op_tag(VT[i].op), VT[i].op, VT[i].sew, 1'b1, 1'b0,
               VT[i].vs2, VT[i].vs1, 64'h0, VT[i].vd, VT[i].exp);

      // reference sweep over every op and width, R7 wraparound included
      for (int op = 0; op < 8; op++)
         for (int s = 0; s < 4; s++)
            for (int n = 0; n < 10; n++) begin
               logic [63:0] a = pick(2'(s));
               logic [63:0] b = pick(2'(s));
               logic [63:0] d = pick(2'(s));
               apply({op_tag(3'(op)), " R7"}, 3'(op), 2'(s), 1'b1, 1'b0, a, b, 64'h0, d,
                     ref_res(3'(op), 2'(s), a, b, d));
            end

      // R7: garbage above SEW ignored, upper result bits zero
      apply("R7 upper", 3'd0, 2'd0, 1'b1, 1'b0, 64'hFFFF_AB03, 64'hFFFF_FF02, 64'h0,
            64'hFFFF_FFFF_FFFF_FFFF, 64'h6);

      // R8: scalar replaces vs1, vs1 ignored
      apply("R8 mul", 3'd0, 2'd0, 1'b1, 1'b1, 64'h5, 64'h77, 64'h1203, 64'h0, 64'hF);
      apply("R8 vs1 ignored", 3'd0, 2'd0, 1'b1, 1'b1, 64'h5, 64'hC9, 64'h1203, 64'h0, 64'hF);
      apply("R8 fma", 3'd6, 2'd1, 1'b1, 1'b1, 64'h1, 64'hFFFF, 64'h2, 64'h4, 64'h9);

      // R9: masked element passes the full old destination
      apply("R9 masked", 3'd1, 2'd0, 1'b0, 1'b0, 64'h80, 64'h80, 64'h0,
            64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
      apply("R9 masked acc", 3'd5, 2'd3, 1'b0, 1'b1, 64'h3, 64'h3, 64'h7,
            64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210);

      // R2: back-to-back stream mixing masked, high half, fma and scalar
      begin
         logic [2:0]  s_op  [5] = '{3'd3, 3'd0, 3'd7, 3'd1, 3'd4};
         logic [1:0]  s_sew [5] = '{2'd1, 2'd3, 2'd0, 2'd2, 2'd3};
         bit          s_mk  [5] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
         bit          s_sc  [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
         logic [63:0] s_exp [5];
         logic [63:0] s_a   [5];
         logic [63:0] s_b   [5];
         logic [63:0] s_d   [5];
         for (int i = 0; i < 5; i++) begin
            s_a[i] = pick(s_sew[i]); s_b[i] = pick(s_sew[i]); s_d[i] = {$urandom, $urandom};
            s_exp[i] = s_mk[i] ? ref_res(s_op[i], s_sew[i], s_a[i], s_b[i], s_d[i]) : s_d[i];
         end
         for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i >= 2) begin
               check("R2 stream valid", {63'd0, out_valid}, 64'd1);
               check("R2 stream result", out_result, s_exp[i-2]);
            end
            if (i < 5) drive(s_op[i], s_sew[i], s_mk[i], s_sc[i], s_a[i], 64'h5A5A, s_b[i], s_d[i]);
            else in_valid = 1'b0;
            if (i < 5 && !s_sc[i]) in_vs1 = s_b[i];
         end
         @(negedge clk);
         check("R2 stream ends", {63'd0, out_valid}, 64'd0);
      end

      // R1: element in flight when reset asserts gives no output
      @(negedge clk);
      drive(3'd0, 2'd0, 1'b1, 1'b0, 64'h2, 64'h3, 64'h0, 64'h0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 flush", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 flush after", {63'd0, out_valid}, 64'd0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule